// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full 2N-bit product of two unsigned N-bit operands. It uses one N-bit adder, which it reuses once per clock cycle. A single 2N-bit accumulator holds the result as it is built. When an operation is accepted, the low half of the accumulator takes the multiplier and the high half is cleared. Each cycle then looks at the least significant accumulator bit. When that bit is set, the cycle adds the stored multiplicand into the high half. Every cycle ends by shifting the whole accumulator right by one, and the carry out of the add enters the top bit. The multiplier therefore needs no register of its own: the shifts consume its bits as the product bits arrive from the top.

The surrounding logic pulses `start` with both operands present. `busy` then stays high for exactly N cycles and `done` pulses for one cycle. The product can be read from `done` onward and holds its value until the next accepted start.

The controller has three states. IDLE waits for `start`; the transition *accept* loads the operands and moves to RUN. RUN performs one iteration per cycle. It stays in RUN (*iterate*) until the last iteration, then takes *finish* to DONE. DONE lasts one cycle and takes *retire* back to IDLE.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen in IDLE is accepted. In the next cycle `busy` is 1 and `product` equals the multiplier in its low N bits and zeros in its high N bits.
- R3: Each RUN cycle tests `product[0]`. If it is 1, the stored multiplicand is added to `product[2N-1:N]`. The (N+1)-bit sum, carry included, then forms the top N+1 bits of a one-bit right shift of the accumulator. For N=4, 0010 times 0110 gives the visible sequence 0000_0110, 0000_0011, 0001_0001, 0001_1000, 0000_1100.
- R4: Exactly N iterations run. `busy` is 1 for N cycles after the accepting edge, and `done` is 1 in cycle N+1.
- R5: `done` is high for a single cycle and is never high together with `busy`.
- R6: `start` has no effect in RUN or DONE. The running operation's result and timing are unchanged, and no new load happens.
- R7: Between `done` and the next accepted start, `product` does not change.
- R8: The final `product` equals the exact unsigned product, including all-ones operands, where the carry into the top bit matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication (honoured in IDLE only) |
| mcand | input | N | Multiplicand, sampled on the accepting edge |
| mplier | input | N | Multiplier, sampled on the accepting edge |
| busy | output | 1 | High while iterations run |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Accumulator contents; final product from `done` on |

## Verification
The assertions check on every cycle the rules that involve only the control signals and ports. These are the one-cycle `done` pulse, the exclusion of `busy` and `done`, the iteration bound, the step from the last iteration to `done`, that no load happens outside IDLE, and that the product holds while idle. The arithmetic itself can only be shown by the bench's scenarios. These are the 4-bit step-by-step trace, exact products for corner and random operands, and start pulses injected mid-run and in the DONE cycle, after which the bench confirms at the ports that nothing changed.

// File: rtl/shiftadd_mult_pkg.sv
package shiftadd_mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

endpackage

// File: rtl/shiftadd_adder.sv
module shiftadd_adder #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         carry_o
);
    logic [N:0] wide;

    always_comb begin
        wide    = {1'b0, a_i} + {1'b0, b_i};
        sum_o   = wide[N-1:0];
        carry_o = wide[N];
    end

endmodule

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl
    import shiftadd_mult_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);
    localparam logic [CW-1:0] ALL_ITER  = CW'(N);

    mul_state_e state_q, state_d;
    logic [CW-1:0] iter_q, iter_d;

    always_comb begin
        state_d = state_q;
        iter_d  = iter_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    iter_d  = '0;
                end
            end
            ST_RUN: begin
                iter_d = iter_q + 1'b1;
                if (iter_q == LAST_ITER) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            iter_q  <= iter_d;
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        load = 1'b0;
        step = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R5: completion pulse lasts one cycle
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: busy and done never overlap
    assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4: iteration counter stays below N while running
    assert_iter_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (iter_q < ALL_ITER));

    // R4: the last iteration is followed by done
    assert_last_to_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iter_q == LAST_ITER) |=> (done && !busy));

endmodule

// File: rtl/shiftadd_datapath.sv
module shiftadd_datapath #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic [2*N-1:0] acc_o
);
    localparam int PW = 2 * N;

    logic [N-1:0]  mcand_q;
    logic [PW-1:0] acc_q, acc_d;
    logic [N-1:0]  addend;
    logic [N-1:0]  upper_sum;
    logic          upper_carry;

    always_comb begin
        addend = acc_q[0] ? mcand_q : '0;
    end

    shiftadd_adder #(.N(N)) u_add (
        .a_i     (acc_q[PW-1:N]),
        .b_i     (addend),
        .sum_o   (upper_sum),
        .carry_o (upper_carry)
    );

    always_comb begin
        acc_d = acc_q;
        if (load) begin
            acc_d = {{N{1'b0}}, mplier_in};
        end else if (step) begin
            acc_d = {upper_carry, upper_sum, acc_q[N-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else begin
            acc_q <= acc_d;
            if (load) begin
                mcand_q <= mcand_in;
            end
        end
    end

    assign acc_o = acc_q;

    // R3: a cycle whose tested bit is 0 is a pure right shift
    assert_zero_bit_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !acc_q[0]) |=> (acc_q == {1'b0, $past(acc_q[PW-1:1])}));

    // R2: a load clears the upper half
    assert_load_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q[PW-1:N] == '0));

endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    logic load;
    logic step;

    shiftadd_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    shiftadd_datapath #(.N(N)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .acc_o     (product)
    );

    // R6: no load while running or completing
    assert_no_load_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || done) |-> !load);

    // R7: product holds when neither running nor loading
    assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(product));

endmodule

// File: tb/sim_shiftadd_mult.sv
module sim_shiftadd_mult;
    localparam int  N      = 32;
    localparam int  NS     = 4;
    localparam time PERIOD = 10ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy, done;
    logic [2*N-1:0] product;

    logic            s_start = 1'b0;
    logic [NS-1:0]   s_mcand = '0;
    logic [NS-1:0]   s_mplier = '0;
    logic            s_busy, s_done;
    logic [2*NS-1:0] s_product;

    int checks = 0;
    int errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    shiftadd_mult #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    shiftadd_mult #(.N(NS)) u1 (
        .clk(clk), .rst_n(rst_n), .start(s_start), .mcand(s_mcand), .mplier(s_mplier),
        .busy(s_busy), .done(s_done), .product(s_product)
    );

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return {{N{1'b0}}, a} * {{N{1'b0}}, b};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Runs one multiplication on u0; optionally pokes start with other
    // operands at cycle poke (0 = never). Returns result and cycles to done.
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b, input int poke,
                           output logic [2*N-1:0] res, output int cyc);
        int cnt = 0;
        bit busy_ok = 1'b1;
        @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        check(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        check(product === {{N{1'b0}}, b}, "R2 load value", product, {{N{1'b0}}, b});
        while (!done && cnt < 4 * N) begin
            if (cnt == poke) begin
                mcand = ~a; mplier = ~b; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            cnt++;
            if (cnt <= N && busy !== 1'b1) busy_ok = 1'b0;
        end
        check(busy_ok, "R4 busy held for N cycles", 64'(busy_ok), 64'd1);
        res = product;
        cyc = cnt;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2*N-1:0] res;
        logic [2*N-1:0] held;
        int cyc;
        logic [2*NS-1:0] trace [5];
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        #(PERIOD * 2 + 1);
        check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {busy, done}, 0);
        check(product === '0, "R1 product in reset", product, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && product === '0, "R1 after release", product, 0);

        // R3: 4-bit trace 0010 x 0110
        trace[0] = 8'b0000_0110; trace[1] = 8'b0000_0011; trace[2] = 8'b0001_0001;
        trace[3] = 8'b0001_1000; trace[4] = 8'b0000_1100;
        s_mcand = 4'b0010; s_mplier = 4'b0110; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            check(s_product === trace[i], $sformatf("R3 trace step %0d", i), 64'(s_product), 64'(trace[i]));
            if (i < 4) @(negedge clk);
        end
        check(s_done === 1'b1 && s_busy === 1'b0, "R4 small done after N", {s_busy, s_done}, 64'd1);

        // R8 / R4: directed corners
        run_mul('0, 32'h1234_5678, 0, res, cyc);
        check(res === '0, "R8 zero multiplicand", res, 0);
        check(cyc == N + 1, "R4 done at cycle N+1", 64'(cyc), 64'(N + 1));
        run_mul(32'hDEAD_BEEF, '0, 0, res, cyc);
        check(res === '0, "R8 zero multiplier", res, 0);
        run_mul(32'd1, 32'hCAFE_F00D, 0, res, cyc);
        check(res === ref_mul(1, 32'hCAFE_F00D), "R8 one", res, ref_mul(1, 32'hCAFE_F00D));
        run_mul('1, '1, 0, res, cyc);
        check(res === ref_mul('1, '1), "R8 all ones carry", res, ref_mul('1, '1));

        // R5: done lasts one cycle
        @(negedge clk);
        check(done === 1'b0, "R5 done single cycle", 64'(done), 0);

        // R6: start mid-run ignored
        run_mul(32'h0F0F_1234, 32'h8000_0001, 5, res, cyc);
        check(res === ref_mul(32'h0F0F_1234, 32'h8000_0001), "R6 mid-run start result",
              res, ref_mul(32'h0F0F_1234, 32'h8000_0001));
        check(cyc == N + 1, "R6 mid-run start timing", 64'(cyc), 64'(N + 1));

        // R6: start in DONE cycle ignored; R7: product holds
        run_mul(32'h0000_FFFF, 32'h0001_0003, 0, res, cyc);
        held = product;
        mcand = 32'h7; mplier = 32'h9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0 && product === held, "R6 start during done ignored", product, held);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(product === held, "R7 product stable while idle", product, held);
        end

        // R8: random operands
        for (int i = 0; i < 40; i++) begin
            logic [N-1:0] a = $urandom;
            logic [N-1:0] b = $urandom;
            if (i % 8 == 0) a = a | 32'h8000_0000;
            run_mul(a, b, 0, res, cyc);
            check(res === ref_mul(a, b), "R8 random product", res, ref_mul(a, b));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule